// File: doc/BRIEF.md
# Interrupt Status and Summary Controller

This block keeps the interrupt status word and the interrupt enable word of a network controller and drives a single level-sensitive interrupt line. The transmit and receive engines pulse event inputs. Each pulse sets a sticky bit in the status word, and software clears those bits by writing ones into the status word.

The block never drives the interrupt line from the raw events. It first folds the events into two summary bits. The normal summary covers routine completions. The abnormal summary covers errors and state changes. Each summary is set only when one of its events is both set and enabled. The summary bits then pass through their own enable bits, and the line is raised one clock later. The status word also carries two 3-bit process-state fields, one for receive and one for transmit. The engines update these fields without disturbing any other bit.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status word reads 0xF0000000, the enable word reads 0xF3FE0000 and `irq_o` is low.
- R2: A one on an event input at an event bit position sets that status bit, and the bit stays set after the input returns to zero. The event bit positions are 0 to 14, 26 and 27.
- R3: A status write (`reg_sel`=0) clears each event bit and each summary bit where the written data is one, and leaves bits written as zero unchanged. Bits 31:28 and the two state fields are never affected by a status write.
- R4: When an event sets a bit in the same cycle that a status write clears it, the bit ends up set.
- R5: Status bit 16 (normal summary) is one exactly when any of bits 0, 2, 6, 11 or 14 is set in the status word and also set in the enable word.
- R6: Status bit 15 (abnormal summary) is one exactly when any of bits 1, 3, 4, 5, 7, 8, 9, 10, 12, 13, 26 or 27 is set in the status word and also set in the enable word.
- R7: An enable write (`reg_sel`=1) stores all 32 bits, and both summaries reflect the new enable word on the same clock edge.
- R8: `irq_o` is high when status bit 16 and enable bit 16 are both set, or when status bit 15 and enable bit 15 are both set. It follows the status and enable words with a delay of one clock.
- R9: Asserting `rx_state_we` loads status bits 19:17 from `rx_state_i`, and asserting `tx_state_we` loads bits 22:20 from `tx_state_i`. No other bit changes.
- R10: Event inputs at positions other than the event positions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Per-bit event set pulses, aligned with status bit positions |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 selects the status word, 1 selects the enable word |
| reg_wdata | input | 32 | Write data |
| rx_state_we | input | 1 | Load strobe for the receive state field |
| rx_state_i | input | 3 | New receive state |
| tx_state_we | input | 1 | Load strobe for the transmit state field |
| tx_state_i | input | 3 | New transmit state |
| status_o | output | 32 | Current status word |
| enable_o | output | 32 | Current enable word |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The assertions check five behaviours on every cycle:
- A pulsed event bit is set on the next cycle, even when a clear arrives with it.
- A written one clears its bit when no event coincides.
- The state fields take their loaded values.
- The reserved top nibble never moves.
- Both summary bits agree with the set-and-enabled events, and the line only rises after a summary was present.

The bench's scenarios are the only way to show the rest:
- The exact reset words.
- That zeros in a write leave bits alone.
- That an enable write alone can raise or drop a summary.
- That bits outside the event positions ignore the event inputs.
- The one-clock lag of the line.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter logic [31:0] STATUS_RST = 32'hF000_0000,
  parameter logic [31:0] ENABLE_RST = 32'hF3FE_0000,
  parameter int          RX_LSB     = 17,
  parameter int          TX_LSB     = 20,
  parameter int          ST_W       = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     evt_i,
  input  logic            reg_we,
  input  logic            reg_sel,
  input  logic [31:0]     reg_wdata,
  input  logic            rx_state_we,
  input  logic [ST_W-1:0] rx_state_i,
  input  logic            tx_state_we,
  input  logic [ST_W-1:0] tx_state_i,
  output logic [31:0]     status_o,
  output logic [31:0]     enable_o,
  output logic            irq_o
);
  localparam int          NSUM_BIT = 16;
  localparam int          ASUM_BIT = 15;
  localparam logic [31:0] NORM_EV  = 32'h0000_4845;
  localparam logic [31:0] ABN_EV   = 32'h0C00_37BA;
  localparam logic [31:0] EVT_MASK = NORM_EV | ABN_EV;
  localparam logic [31:0] SUM_MASK = (32'h1 << NSUM_BIT) | (32'h1 << ASUM_BIT);
  localparam logic [31:0] CLR_MASK = EVT_MASK | SUM_MASK;
  localparam logic [31:0] RX_MASK  = ((32'h1 << ST_W) - 1) << RX_LSB;
  localparam logic [31:0] TX_MASK  = ((32'h1 << ST_W) - 1) << TX_LSB;

  logic [31:0] status_q, enable_q, enable_d, status_d, events_d;
  logic        irq_q;

  wire wr_status = reg_we && !reg_sel;
  wire wr_enable = reg_we &&  reg_sel;
  wire [31:0] clr = wr_status ? (reg_wdata & CLR_MASK) : 32'h0;

  assign enable_d = wr_enable ? reg_wdata : enable_q;

  always_comb begin
    events_d = ((status_q & ~clr) | (evt_i & EVT_MASK)) & EVT_MASK;
    status_d = (status_q & ~(EVT_MASK | SUM_MASK)) | events_d;
    if (rx_state_we)
      status_d = (status_d & ~RX_MASK) | ({29'h0, rx_state_i} << RX_LSB);
    if (tx_state_we)
      status_d = (status_d & ~TX_MASK) | ({29'h0, tx_state_i} << TX_LSB);
    status_d[NSUM_BIT] = |(events_d & enable_d & NORM_EV);
    status_d[ASUM_BIT] = |(events_d & enable_d & ABN_EV);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= STATUS_RST;
      enable_q <= ENABLE_RST;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      irq_q    <= |(status_q & enable_q & SUM_MASK);
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = irq_q;

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    |(evt_i & EVT_MASK) |=> ((status_o & $past(evt_i & EVT_MASK)) == $past(evt_i & EVT_MASK))); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel) |=> ((status_o & $past(reg_wdata & ~evt_i & EVT_MASK)) == 32'h0)); // R3
  AST_RX_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_state_we |=> (status_o[RX_LSB +: ST_W] == $past(rx_state_i))); // R9
  AST_TX_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_state_we |=> (status_o[TX_LSB +: ST_W] == $past(tx_state_i))); // R9
  AST_TOP_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[31:28] == STATUS_RST[31:28]); // R3
  AST_NORM_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[NSUM_BIT] == (|(status_o & enable_o & NORM_EV))); // R5
  AST_ABN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[ASUM_BIT] == (|(status_o & enable_o & ABN_EV))); // R6
  AST_IRQ_AFTER_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(status_o[NSUM_BIT] || status_o[ASUM_BIT])); // R8
endmodule

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] evt_i = 0;
  logic        reg_we = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic        rx_state_we = 0, tx_state_we = 0;
  logic [2:0]  rx_state_i = 0, tx_state_i = 0;
  logic [31:0] status_o, enable_o;
  logic        irq_o;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  irq_status_ctrl dut (.clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rx_state_we(rx_state_we),
    .rx_state_i(rx_state_i), .tx_state_we(tx_state_we), .tx_state_i(tx_state_i),
    .status_o(status_o), .enable_o(enable_o), .irq_o(irq_o));

  typedef struct packed {
    logic [31:0] evt;
    logic        wr;
    logic        sel;
    logic [31:0] wd;
    logic [31:0] st;
    logic        irq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 1'b1, 1'b1, 32'h0001_8001, 32'hF000_0000, 1'b0}, // R7 enable write
    '{32'h0000_0001, 1'b0, 1'b0, 32'h0,         32'hF001_0001, 1'b1}, // R2 R5 R8
    '{32'h0000_0000, 1'b0, 1'b0, 32'h0,         32'hF001_0001, 1'b1}, // R2 sticky
    '{32'h0000_0000, 1'b1, 1'b0, 32'h0000_0001, 32'hF000_0000, 1'b0}, // R3 clear
    '{32'h0000_0002, 1'b0, 1'b0, 32'h0,         32'hF000_0002, 1'b0}, // R6 masked
    '{32'h0000_0000, 1'b1, 1'b1, 32'h0001_8003, 32'hF000_8002, 1'b1}, // R7 R6
    '{32'h0800_0000, 1'b1, 1'b0, 32'h0000_0002, 32'hF800_0000, 1'b0}, // R3 R6
    '{32'h0000_0000, 1'b1, 1'b1, 32'h0801_8003, 32'hF800_8000, 1'b1}, // R7 R6
    '{32'h0800_0000, 1'b1, 1'b0, 32'h0800_0000, 32'hF800_8000, 1'b1}, // R4
    '{32'h0000_0000, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hF000_0000, 1'b0}, // R3 all ones
    '{32'hF3FF_8000, 1'b0, 1'b0, 32'h0,         32'hF000_0000, 1'b0}, // R10
    '{32'h0000_0004, 1'b0, 1'b0, 32'h0,         32'hF000_0004, 1'b0}  // R5 masked
  };

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    evt_i = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    rx_state_we = 0; tx_state_we = 0;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk32("R1 status", status_o, 32'hF000_0000);
    chk32("R1 enable", enable_o, 32'hF3FE_0000);
    chk32("R1 irq", {31'h0, irq_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      evt_i = VECS[i].evt; reg_we = VECS[i].wr; reg_sel = VECS[i].sel;
      reg_wdata = VECS[i].wd;
      @(posedge clk);
      idle();
      chk32($sformatf("R2-vector %0d status", i), status_o, VECS[i].st);
      @(negedge clk);
      chk32($sformatf("R8-vector %0d irq", i), {31'h0, irq_o}, {31'h0, VECS[i].irq});
    end
    chk32("R7 enable readback", enable_o, 32'h0801_8003);

    // R8: one-clock lag. Enable bit 2 is clear, so set it first.
    reg_we = 1; reg_sel = 1; reg_wdata = 32'h0801_8007;
    @(posedge clk); idle();
    chk32("R5 summary via enable", status_o, 32'hF001_0004);
    chk32("R8 lag low", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    chk32("R8 lag high", {31'h0, irq_o}, 32'h1);
    reg_we = 1; reg_sel = 1; reg_wdata = 32'h0801_8003;
    @(posedge clk); idle();
    chk32("R7 summary drop", status_o, 32'hF000_0004);
    chk32("R8 still high", {31'h0, irq_o}, 32'h1);
    @(negedge clk);
    chk32("R8 falls", {31'h0, irq_o}, 32'h0);

    // R9: state fields
    rx_state_we = 1; rx_state_i = 3'd5;
    @(posedge clk); idle();
    chk32("R9 rx field", status_o, 32'hF00A_0004);
    tx_state_we = 1; tx_state_i = 3'd3;
    @(posedge clk); idle();
    chk32("R9 tx field", status_o, 32'hF03A_0004);
    reg_we = 1; reg_sel = 0; reg_wdata = 32'hFFFF_FFFF;
    @(posedge clk); idle();
    chk32("R3 fields kept", status_o, 32'hF03A_0000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule